// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed 32-bit words and adds the signed 64-bit product into a 64-bit accumulator. The accumulator is visible as a high half and a low half. Both operands come from memory. A request port carries a valid/ready handshake and returns the read data in the cycle that ready is high. Two address pointers select the operands, and each pointer advances by one word (4 bytes) after its read completes. The advanced pointers come back out of the block so that the caller can step through arrays.

A mode bit, sampled when start is accepted, selects how the product is added. In wrap mode the product is added to the full 64-bit accumulator modulo 2^64. In saturating mode only the low 48 bits of the accumulator take part, sign-extended. The exact sum is clamped to the signed 48-bit range, and the clamped value is stored sign-extended to 64 bits.

The caller pulses start with both pointers and the mode, then waits for the one-cycle done pulse. The accumulator halves can be written from outside while the unit is idle.

Top module: `sat_mac_unit`

## Requirements
- R1: In wrap mode (sat_mode=0), the new accumulator equals the old {acc_hi,acc_lo} plus the signed 64-bit product of the two operands, modulo 2^64. This holds for every sign combination, including 0x8000_0000 times 0x8000_0000.
- R2: In saturating mode (sat_mode=1), the result is old acc[47:0] sign-extended, plus the product, computed exactly. It is clamped to the range 0xFFFF_8000_0000_0000 to 0x0000_7FFF_FFFF_FFFF, so the stored value always equals bit 47 repeated through bit 63.
- R3: Each operation issues exactly two reads. The first read is at the value of ptr_a_in captured at start, and the second at the value of ptr_b_in captured at start. The first read's data is the first operand.
- R4: ptr_a_out and ptr_b_out each increase by exactly 4 when their own read completes. After done they equal the captured start values plus 4.
- R5: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_addr stays unchanged.
- R6: With start accepted at a clock edge, done is high after edge 4 + W, where W is the number of cycles in which rd_valid was high and rd_ready low. done stays high for exactly one cycle. The new accumulator is visible on acc_hi/acc_lo in that same cycle.
- R7: While the unit is idle (busy=0), acc_load writes acc_load_hi and acc_load_lo into the accumulator, and they are visible in the next cycle. A load in the same cycle as an accepted start is used by that operation.
- R8: acc_load while busy=1 has no effect on the accumulator.
- R9: start while busy=1 is ignored. It starts no extra reads and changes no pointer.
- R10: In saturating mode, accumulator bits 63..48 do not affect the result.
- R11: After reset the accumulator and both pointer outputs are zero, and done, busy and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| sat_mode | input | 1 | 1 = 48-bit saturating accumulate, 0 = 64-bit wrap |
| ptr_a_in | input | 32 | Address of first operand |
| ptr_b_in | input | 32 | Address of second operand |
| ptr_a_out | output | 32 | First pointer, advanced after its read |
| ptr_b_out | output | 32 | Second pointer, advanced after its read |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 32 | Read address |
| rd_ready | input | 1 | Memory completes the read this cycle |
| rd_data | input | 32 | Read data, valid with rd_ready |
| acc_load | input | 1 | Write accumulator halves (idle only) |
| acc_load_hi | input | 32 | High half to load |
| acc_load_lo | input | 32 | Low half to load |
| acc_hi | output | 32 | Accumulator bits 63..32 |
| acc_lo | output | 32 | Accumulator bits 31..0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: accumulator updated |

## Verification
An outside load of the accumulator and an internal accumulator write can coincide in two ways. The bench covers both.

In the first case, a load is driven in the same cycle as start. The bench judges this case by requiring that the result is built on the loaded value.

In the second case, load and a second start are held high through every busy cycle, including the cycle in which the sum is written. The bench judges this case by requiring three things:
- the written result matches the reference model;
- only two reads occur;
- the pointers step only once each.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int DW    = 32;
    localparam int ACC_W = 2 * DW;
    localparam int SAT_W = 48;

    typedef logic signed [DW-1:0]    word_t;
    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [ACC_W:0]   wide_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_EXEC
    } mac_state_e;

    typedef struct packed {
        word_t op_a;
        word_t op_b;
        logic  sat;
    } operands_t;

    function automatic logic [DW-1:0] magnitude(input word_t v);
        return v[DW-1] ? (~v + 1'b1) : v;
    endfunction

    function automatic acc_t clamp_sat(input wide_t s);
        wide_t hi_lim;
        wide_t lo_lim;
        hi_lim = wide_t'((65'sd1 <<< (SAT_W - 1)) - 65'sd1);
        lo_lim = -hi_lim - 65'sd1;
        if (s > hi_lim)      return acc_t'(hi_lim);
        else if (s < lo_lim) return acc_t'(lo_lim);
        else                 return acc_t'(s);
    endfunction

endpackage

// File: rtl/mac_fetch.sv
module mac_fetch
    import mac_pkg::*;
#(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          sat_in,
    input  logic [AW-1:0] ptr_a_in,
    input  logic [AW-1:0] ptr_b_in,
    input  logic          rd_ready,
    input  logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] ptr_a_q,
    output logic [AW-1:0] ptr_b_q,
    output operands_t     ops,
    output logic          exec,
    output logic          busy
);

    localparam logic [AW-1:0] INC = AW'(STEP);

    mac_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ptr_a_q <= '0;
            ptr_b_q <= '0;
            ops     <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    ptr_a_q <= ptr_a_in;
                    ptr_b_q <= ptr_b_in;
                    ops.sat <= sat_in;
                    state   <= ST_RD_A;
                end
                ST_RD_A: if (rd_ready) begin
                    ops.op_a <= rd_data;
                    ptr_a_q  <= ptr_a_q + INC;
                    state    <= ST_RD_B;
                end
                ST_RD_B: if (rd_ready) begin
                    ops.op_b <= rd_data;
                    ptr_b_q  <= ptr_b_q + INC;
                    state    <= ST_EXEC;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_valid = (state == ST_RD_A) || (state == ST_RD_B);
    assign rd_addr  = (state == ST_RD_B) ? ptr_b_q : ptr_a_q;
    assign exec     = (state == ST_EXEC);
    assign busy     = (state != ST_IDLE);

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R5

    AST_PTR_A_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_A && rd_ready) |=> (ptr_a_q == $past(ptr_a_q) + INC)); // R4

    AST_PTR_B_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_B && rd_ready) |=> (ptr_b_q == $past(ptr_b_q) + INC)); // R4

    AST_EXEC_ONCE: assert property (@(posedge clk) disable iff (rst)
        exec |=> !busy); // R9

endmodule

// File: rtl/mac_mul.sv
module mac_mul
    import mac_pkg::*;
(
    input  word_t op_a,
    input  word_t op_b,
    output acc_t  product
);

    logic             neg;
    logic [DW-1:0]    mag_a;
    logic [DW-1:0]    mag_b;
    logic [ACC_W-1:0] mag_p;

    always_comb begin
        neg     = op_a[DW-1] ^ op_b[DW-1];
        mag_a   = magnitude(op_a);
        mag_b   = magnitude(op_b);
        mag_p   = ACC_W'(mag_a) * ACC_W'(mag_b);
        product = neg ? acc_t'(~mag_p + 1'b1) : acc_t'(mag_p);
    end

endmodule

// File: rtl/mac_acc.sv
module mac_acc
    import mac_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          exec,
    input  logic          busy,
    input  logic          sat,
    input  acc_t          product,
    input  logic          ld,
    input  logic [DW-1:0] ld_hi,
    input  logic [DW-1:0] ld_lo,
    output acc_t          acc,
    output logic          done
);

    acc_t  acc_ext;
    wide_t exact;
    acc_t  next_val;

    always_comb begin
        acc_ext  = acc_t'({{(ACC_W-SAT_W){acc[SAT_W-1]}}, acc[SAT_W-1:0]});
        exact    = wide_t'(product) + wide_t'(acc_ext);
        next_val = sat ? clamp_sat(exact) : acc + product;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            done <= 1'b0;
        end else begin
            done <= exec;
            if (exec)            acc <= next_val;
            else if (ld && !busy) acc <= {ld_hi, ld_lo};
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        exec |=> done); // R6

    AST_SAT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (exec && sat) |=> (&acc[ACC_W-1:SAT_W-1] || ~|acc[ACC_W-1:SAT_W-1])); // R2

    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ld && busy && !exec) |=> $stable(acc)); // R8

endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit
    import mac_pkg::*;
#(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          sat_mode,
    input  logic [AW-1:0] ptr_a_in,
    input  logic [AW-1:0] ptr_b_in,
    output logic [AW-1:0] ptr_a_out,
    output logic [AW-1:0] ptr_b_out,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ready,
    input  logic [31:0]   rd_data,
    input  logic          acc_load,
    input  logic [31:0]   acc_load_hi,
    input  logic [31:0]   acc_load_lo,
    output logic [31:0]   acc_hi,
    output logic [31:0]   acc_lo,
    output logic          busy,
    output logic          done
);

    operands_t ops;
    logic      exec;
    acc_t      product;
    acc_t      acc;

    mac_fetch #(.AW(AW), .STEP(STEP)) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .sat_in   (sat_mode),
        .ptr_a_in (ptr_a_in),
        .ptr_b_in (ptr_b_in),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_addr  (rd_addr),
        .ptr_a_q  (ptr_a_out),
        .ptr_b_q  (ptr_b_out),
        .ops      (ops),
        .exec     (exec),
        .busy     (busy)
    );

    mac_mul u_mul (
        .op_a    (ops.op_a),
        .op_b    (ops.op_b),
        .product (product)
    );

    mac_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .exec    (exec),
        .busy    (busy),
        .sat     (ops.sat),
        .product (product),
        .ld      (acc_load),
        .ld_hi   (acc_load_hi),
        .ld_lo   (acc_load_lo),
        .acc     (acc),
        .done    (done)
    );

    assign acc_hi = acc[ACC_W-1:DW];
    assign acc_lo = acc[DW-1:0];

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!done && !rd_valid && acc == '0)); // R11

endmodule

// File: tb/sat_mac_unit_tb.sv
module sat_mac_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, sat_mode, rd_ready, acc_load;
    logic [31:0] ptr_a_in, ptr_b_in, rd_data, acc_load_hi, acc_load_lo;
    logic [31:0] ptr_a_out, ptr_b_out, rd_addr, acc_hi, acc_lo;
    logic        rd_valid, busy, done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] mem_a_addr, mem_b_addr, mem_a_val, mem_b_val;
    logic [63:0] model_acc;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_mac_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .sat_mode(sat_mode),
        .ptr_a_in(ptr_a_in), .ptr_b_in(ptr_b_in),
        .ptr_a_out(ptr_a_out), .ptr_b_out(ptr_b_out),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .acc_load(acc_load), .acc_load_hi(acc_load_hi), .acc_load_lo(acc_load_lo),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .busy(busy), .done(done)
    );

    always_comb begin
        if (rd_addr == mem_a_addr)      rd_data = mem_a_val;
        else if (rd_addr == mem_b_addr) rd_data = mem_b_val;
        else                            rd_data = 32'hDEAD_BEEF;
    end

    function automatic logic [63:0] ref_mac(input logic [63:0] acc, input logic [31:0] a,
                                            input logic [31:0] b, input logic sat);
        logic signed [127:0] p, s, hi48, lo48;
        p = $signed({{96{a[31]}}, a}) * $signed({{96{b[31]}}, b});
        if (!sat) begin
            s = p + $signed({{64{acc[63]}}, acc});
            return s[63:0];
        end
        s    = p + $signed({{80{acc[47]}}, acc[47:0]});
        hi48 = 128'sh7FFF_FFFF_FFFF;
        lo48 = -hi48 - 128'sd1;
        if (s > hi48)      s = hi48;
        else if (s < lo48) s = lo48;
        return s[63:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic do_load(input logic [63:0] v);
        @(negedge clk);
        acc_load = 1; {acc_load_hi, acc_load_lo} = v;
        @(negedge clk);
        acc_load = 0;
        model_acc = v;
        chk({acc_hi, acc_lo} == v, "R7 idle load", {acc_hi, acc_lo}, v);
    endtask

    // wait_pct: chance (0..100) of rd_ready low per request cycle
    task automatic run_op(input logic [31:0] pa, input logic [31:0] pb, input logic [31:0] a,
                          input logic [31:0] b, input logic sat, input int wait_pct,
                          input bit load_with_start, input logic [63:0] ld_val,
                          input bit disturb);
        logic [31:0] log_addr [2];
        int n_rd, cycles, waits;
        logic [63:0] exp;
        mem_a_addr = pa; mem_b_addr = pb; mem_a_val = a; mem_b_val = b;
        n_rd = 0; cycles = 0; waits = 0;
        @(negedge clk);
        start = 1; sat_mode = sat; ptr_a_in = pa; ptr_b_in = pb;
        if (load_with_start) begin
            acc_load = 1; {acc_load_hi, acc_load_lo} = ld_val; model_acc = ld_val;
        end
        exp = ref_mac(model_acc, a, b, sat);
        forever begin
            @(negedge clk);
            cycles++;
            start = 0; acc_load = 0;
            if (done || cycles > 200) break;
            if (disturb) begin
                // R8 / R9: load and start held while busy must be ignored
                start = 1; ptr_a_in = 32'h0000_F000; ptr_b_in = 32'h0000_F100;
                acc_load = 1; acc_load_hi = 32'h1234_5678; acc_load_lo = 32'h9ABC_DEF0;
            end
            rd_ready = ($urandom % 100) >= wait_pct;
            if (rd_valid && !rd_ready) waits++;
            if (rd_valid && rd_ready) begin
                if (n_rd < 2) log_addr[n_rd] = rd_addr;
                n_rd++;
            end
        end
        start = 0; acc_load = 0;
        chk(done == 1, "R6 done seen", {63'd0, done}, 64'd1);
        chk(cycles == 4 + waits, "R6 latency", 64'(cycles), 64'(4 + waits));
        if (sat) chk({acc_hi, acc_lo} == exp, "R2 sat result", {acc_hi, acc_lo}, exp);
        else     chk({acc_hi, acc_lo} == exp, "R1 wrap result", {acc_hi, acc_lo}, exp);
        chk(n_rd == 2, "R3/R9 read count", 64'(n_rd), 64'd2);
        if (n_rd == 2) begin
            chk(log_addr[0] == pa, "R3 first read addr", {32'd0, log_addr[0]}, {32'd0, pa});
            chk(log_addr[1] == pb, "R3 second read addr", {32'd0, log_addr[1]}, {32'd0, pb});
        end
        chk(ptr_a_out == pa + 4, "R4 ptr_a step", {32'd0, ptr_a_out}, {32'd0, pa + 32'd4});
        chk(ptr_b_out == pb + 4, "R4 ptr_b step", {32'd0, ptr_b_out}, {32'd0, pb + 32'd4});
        model_acc = exp;
        @(negedge clk);
        chk(done == 0, "R6 done one cycle", {63'd0, done}, 64'd0);
        chk(rd_valid == 0 && busy == 0, "R9 no extra op", {62'd0, rd_valid, busy}, 64'd0);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd20240611);
        rst = 1; start = 0; sat_mode = 0; ptr_a_in = 0; ptr_b_in = 0;
        rd_ready = 1; acc_load = 0; acc_load_hi = 0; acc_load_lo = 0;
        mem_a_addr = 0; mem_b_addr = 0; mem_a_val = 0; mem_b_val = 0;
        model_acc = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk({acc_hi, acc_lo} == 64'd0, "R11 acc reset", {acc_hi, acc_lo}, 64'd0);
        chk({done, busy, rd_valid} == 3'b000, "R11 ctrl reset", {61'd0, done, busy, rd_valid}, 64'd0);
        chk(ptr_a_out == 0 && ptr_b_out == 0, "R11 ptr reset", {ptr_a_out, ptr_b_out}, 64'd0);

        // R1 directed: most negative squared, mixed signs, zero-wait
        run_op(32'h100, 32'h200, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 0);
        run_op(32'h104, 32'h204, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, 0, 0);
        run_op(32'h108, 32'h208, 32'h1234_5678, 32'hF000_0001, 0, 30, 0, 0, 0);
        do_load(64'hFFFF_FFFF_FFFF_FFFF);
        run_op(32'h10C, 32'h20C, 32'd1, 32'd1, 0, 0, 0, 0, 0);
        // R2: at and beyond both limits
        do_load(64'h0000_7FFF_FFFF_FFFF);
        run_op(32'h300, 32'h400, 32'd0, 32'd5, 1, 0, 0, 0, 0);
        run_op(32'h304, 32'h404, 32'd1, 32'd1, 1, 0, 0, 0, 0);
        do_load(64'hFFFF_8000_0000_0000);
        run_op(32'h308, 32'h408, 32'hFFFF_FFFF, 32'd1, 1, 0, 0, 0, 0);
        run_op(32'h30C, 32'h40C, 32'h8000_0000, 32'h8000_0000, 1, 0, 0, 0, 0);
        run_op(32'h310, 32'h410, 32'h8000_0000, 32'h7FFF_FFFF, 1, 0, 0, 0, 0);
        // R10: upper accumulator bits ignored in saturating mode
        do_load(64'hABCD_0000_0000_1000);
        run_op(32'h500, 32'h600, 32'd3, 32'd7, 1, 0, 0, 0, 0);
        // R7: load in same cycle as start
        run_op(32'h504, 32'h604, 32'd10, 32'd10, 0, 0, 1, 64'h0000_0001_0000_0000, 0);
        // R8/R9: load and start during busy with waits
        run_op(32'h508, 32'h608, 32'h0BAD_F00D, 32'hC0FF_EE00, 0, 40, 0, 0, 1);
        run_op(32'h50C, 32'h60C, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 40, 0, 0, 1);

        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [31:0] ra, rb;
            int k;
            k  = $urandom % 8;
            ra = (k == 0) ? 32'h8000_0000 : (k == 1) ? 32'h7FFF_FFFF : $urandom;
            rb = (k == 2) ? 32'h8000_0000 : $urandom;
            if (i % 10 == 3) do_load({$urandom, $urandom});
            run_op(32'h1000 + i * 16, 32'h8000 + i * 16, ra, rb, 1'($urandom % 2),
                   int'($urandom % 50), 0, 0, (i % 7) == 0);
        end
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule